// File: doc/BRIEF.md
# PWM Event-Driven Output Shaper

This block produces two PWM pin levels, A and B, from events on the time base. The counter itself is not part of the block. It supplies the count value, the count direction and two strobes, one for when the count is zero and one for when it equals the period. The block contains two comparators, each holding a 16-bit compare value, and each comparator raises an up-count match event. Each output has its own 16-bit action word. For each of the four events, that word holds a 2-bit code that says what the pin does when the event occurs: keep its level, go low, go high or toggle.

No compare result is wired directly to a pin. The duty cycle and the polarity both come from how software programs the action words. A normal-polarity waveform sets the pin high at zero and at period, and clears it on the matching compare. An inverted waveform uses the opposite three codes. The pins are plain control levels: there is no stream interface and no handshake. Each pin is a register that updates on the clock edge that samples the event.

Top module: `pwm_event_shaper`

## Requirements
- R1: After reset both outputs are low, and they stay low until an event with a non-keep action arrives.
- R2: The action codes are 2'b00 keep the level, 2'b01 drive low, 2'b10 drive high and 2'b11 invert the current level.
- R3: In each action word the zero event is bits [1:0], the period event is bits [3:2], compare-A-up is bits [5:4] and compare-B-up is bits [9:8]. Bits [7:6] and [15:10] have no effect on the output.
- R4: A compare event fires only in a cycle where count_up is 1 and the count equals that compare value. A matching count while counting down, or a non-matching count, leaves the output unchanged.
- R5: When several events occur in one cycle, zero beats period, period beats compare-A-up, and compare-A-up beats compare-B-up.
- R6: An occurring event whose code is keep does not block a lower-priority event that occurs in the same cycle.
- R7: Output A follows only the A action word and output B follows only the B action word. Both see the same four events.
- R8: The output takes its new level on the clock edge that samples the event, which is one register of latency.
- R9: For an up counter that wraps 0..P, with 1 <= compare A < P, the A word set to zero=high, period=high, compare-A-up=low gives a pin that is high for compare+1 of every P+1 cycles. The inverted word (low, low, high) gives a pin that is low for compare+1 of every P+1 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| count | input | 16 | Current time-base count |
| count_up | input | 1 | 1 while the counter is counting up |
| at_zero | input | 1 | Count-equals-zero strobe |
| at_period | input | 1 | Count-equals-period strobe |
| cmp_a | input | 16 | Compare value A |
| cmp_b | input | 16 | Compare value B |
| act_a | input | 16 | Action word for output A |
| act_b | input | 16 | Action word for output B |
| pwm_a | output | 1 | Output A pin level |
| pwm_b | output | 1 | Output B pin level |

## Verification
The bench puts several events into the same cycle, in different combinations. A priority chain in the wrong order then leaves the pin at the lower-priority event's level. A design that treats a keep code as a winner freezes the pin where a lower event should have moved it. Matching counts are also driven while counting down, and junk is placed in the unused action-word bits. A comparator that ignores direction, or a wrong field slice, therefore shows up as a spurious edge. Finally, full counter sweeps with both polarity programs measure the high time. This exposes an off-by-one in latency or a period event that is ignored.

// File: rtl/pwm_ev_pkg.sv
package pwm_ev_pkg;
  typedef enum logic [1:0] {
    ACT_KEEP = 2'b00,
    ACT_LOW  = 2'b01,
    ACT_HIGH = 2'b10,
    ACT_FLIP = 2'b11
  } act_e;

  // event index order is also the priority order (0 = strongest)
  localparam int EV_ZERO = 0;
  localparam int EV_PRD  = 1;
  localparam int EV_CMPA = 2;
  localparam int EV_CMPB = 3;
  localparam int EV_NUM  = 4;

  function automatic int ev_lsb(input int idx);
    case (idx)
      EV_ZERO: ev_lsb = 0;
      EV_PRD:  ev_lsb = 2;
      EV_CMPA: ev_lsb = 4;
      default: ev_lsb = 8;
    endcase
  endfunction
endpackage

// File: rtl/pwm_cmp_unit.sv
module pwm_cmp_unit #(
  parameter int CNT_W = 16
) (
  input  logic [CNT_W-1:0] count,
  input  logic             count_up,
  input  logic [CNT_W-1:0] value,
  output logic             hit
);
  always_comb hit = count_up && (count == value);
endmodule

// File: rtl/pwm_act_select.sv
module pwm_act_select
  import pwm_ev_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic [WORD_W-1:0] word,
  input  logic [EV_NUM-1:0] events,
  output act_e              act
);
  logic [1:0] code [EV_NUM];

  for (genvar g = 0; g < EV_NUM; g++) begin : g_field
    assign code[g] = word[ev_lsb(g) +: 2];
  end

  // walk from weakest to strongest so the strongest effective event wins
  always_comb begin
    act = ACT_KEEP;
    for (int i = EV_NUM - 1; i >= 0; i--) begin
      if (events[i] && (code[i] != 2'b00)) act = act_e'(code[i]);
    end
  end
endmodule

// File: rtl/pwm_level_reg.sv
module pwm_level_reg
  import pwm_ev_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  act_e act,
  output logic level
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level <= 1'b0;
    else begin
      case (act)
        ACT_LOW:  level <= 1'b0;
        ACT_HIGH: level <= 1'b1;
        ACT_FLIP: level <= ~level;
        default:  level <= level;
      endcase
    end
  end

  // R2
  keep_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_KEEP) |=> $stable(level));
endmodule

// File: rtl/pwm_event_shaper.sv
module pwm_event_shaper
  import pwm_ev_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  count,
  input  logic              count_up,
  input  logic              at_zero,
  input  logic              at_period,
  input  logic [CNT_W-1:0]  cmp_a,
  input  logic [CNT_W-1:0]  cmp_b,
  input  logic [WORD_W-1:0] act_a,
  input  logic [WORD_W-1:0] act_b,
  output logic              pwm_a,
  output logic              pwm_b
);
  localparam int NCMP = 2;
  localparam int NOUT = 2;

  logic [CNT_W-1:0]  cmp_val [NCMP];
  logic [NCMP-1:0]   cmp_hit;
  logic [WORD_W-1:0] words   [NOUT];
  logic [NOUT-1:0]   levels;
  logic [EV_NUM-1:0] events;

  assign cmp_val[0] = cmp_a;
  assign cmp_val[1] = cmp_b;
  assign words[0]   = act_a;
  assign words[1]   = act_b;

  for (genvar c = 0; c < NCMP; c++) begin : g_cmp
    pwm_cmp_unit #(.CNT_W(CNT_W)) u_cmp (
      .count(count), .count_up(count_up), .value(cmp_val[c]), .hit(cmp_hit[c])
    );
  end

  always_comb begin
    events          = '0;
    events[EV_ZERO] = at_zero;
    events[EV_PRD]  = at_period;
    events[EV_CMPA] = cmp_hit[0];
    events[EV_CMPB] = cmp_hit[1];
  end

  for (genvar k = 0; k < NOUT; k++) begin : g_out
    act_e act;
    pwm_act_select #(.WORD_W(WORD_W)) u_sel (
      .word(words[k]), .events(events), .act(act)
    );
    pwm_level_reg u_lvl (
      .clk(clk), .rst_n(rst_n), .act(act), .level(levels[k])
    );
  end

  assign pwm_a = levels[0];
  assign pwm_b = levels[1];

  // R1
  reset_low_chk: assert property (@(posedge clk)
    !rst_n |=> (!pwm_a && !pwm_b));
  // R5
  zero_high_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (at_zero && act_a[1:0] == 2'b10) |=> pwm_a);
  // R5
  zero_low_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (at_zero && act_b[1:0] == 2'b01) |=> !pwm_b);
  // R2
  zero_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (at_zero && act_a[1:0] == 2'b11) |=> (pwm_a != $past(pwm_a)));
  // R4
  quiet_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!at_zero && !at_period && !(count_up && count == cmp_a)
     && !(count_up && count == cmp_b)) |=> ($stable(pwm_a) && $stable(pwm_b)));
endmodule

// File: tb/pwm_event_shaper_bench.sv
`timescale 1ns/1ps
module pwm_event_shaper_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] count = '0;
  logic        count_up = 1'b0, at_zero = 1'b0, at_period = 1'b0;
  logic [15:0] cmp_a = '0, cmp_b = '0, act_a = '0, act_b = '0;
  logic        pwm_a, pwm_b;

  pwm_event_shaper u_pwm_event_shaper (
    .clk(clk), .rst_n(rst_n), .count(count), .count_up(count_up),
    .at_zero(at_zero), .at_period(at_period), .cmp_a(cmp_a), .cmp_b(cmp_b),
    .act_a(act_a), .act_b(act_b), .pwm_a(pwm_a), .pwm_b(pwm_b)
  );

  always #2.5 clk = ~clk;

  typedef struct { logic a; logic b; string tag; bit tally; } exp_t;
  exp_t q[$];
  int total = 0, bad = 0, hi_a = 0, lo_b = 0;
  logic ma = 1'b0, mb = 1'b0;
  logic [15:0] nw_a = '0, nw_b = '0, nc_a = '0, nc_b = '0;

  function automatic logic model(logic cur, logic [15:0] w, logic z, logic p,
                                 logic ha, logic hb);
    logic [1:0] c;
    c = 2'b00;
    if (hb && w[9:8] != 2'b00) c = w[9:8];
    if (ha && w[5:4] != 2'b00) c = w[5:4];
    if (p  && w[3:2] != 2'b00) c = w[3:2];
    if (z  && w[1:0] != 2'b00) c = w[1:0];
    case (c)
      2'b01:   return 1'b0;
      2'b10:   return 1'b1;
      2'b11:   return ~cur;
      default: return cur;
    endcase
  endfunction

  task automatic step(input logic z, input logic p, input logic up,
                      input logic [15:0] cnt, input string tag, input bit tally = 0);
    logic ha, hb;
    exp_t e;
    @(negedge clk);
    act_a = nw_a; act_b = nw_b; cmp_a = nc_a; cmp_b = nc_b;
    at_zero = z; at_period = p; count_up = up; count = cnt;
    ha = up && (cnt == nc_a);
    hb = up && (cnt == nc_b);
    ma = model(ma, nw_a, z, p, ha, hb);
    mb = model(mb, nw_b, z, p, ha, hb);
    e.a = ma; e.b = mb; e.tag = tag; e.tally = tally;
    q.push_back(e);
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: pops the item pushed before the last edge
  always begin
    @(posedge clk);
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check(pwm_a === e.a, {e.tag, " out A"}, int'(pwm_a), int'(e.a));
      check(pwm_b === e.b, {e.tag, " out B"}, int'(pwm_b), int'(e.b));
      if (e.tally && pwm_a) hi_a++;
      if (e.tally && !pwm_b) lo_b++;
    end
  end

  task automatic sweep(input int per, input bit tally, input string tag);
    for (int c = 0; c <= per; c++)
      step(c == 0, c == per, 1'b1, 16'(c), tag, tally);
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    nc_a = 16'hFFF0; nc_b = 16'hFFF1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #0.5;
    // R1 reset state
    check(pwm_a === 1'b0 && pwm_b === 1'b0, "R1 reset", int'({pwm_a, pwm_b}), 0);
    nw_a = 16'h0000; nw_b = 16'h0000;
    step(1, 1, 1, 16'd5, "R1 idle");

    // R2 codes on the zero field
    nw_a = 16'h0002; nw_b = 16'h0003;
    step(1, 0, 0, 16'd9, "R2 high/flip");
    nw_a = 16'h0001; nw_b = 16'h0003;
    step(1, 0, 0, 16'd9, "R2 low/flip");
    nw_a = 16'h0003; nw_b = 16'h0000;
    step(1, 0, 0, 16'd9, "R2 flip/keep");
    step(1, 0, 0, 16'd9, "R2 flip again");
    step(0, 0, 0, 16'd9, "R8 no event holds");

    // R3 each field alone, junk in unused bits
    nw_a = 16'hFCC0 | 16'h0008; nw_b = 16'hFCC0 | 16'h0004;
    step(0, 1, 0, 16'd1, "R3 period field");
    nc_a = 16'd20; nw_a = 16'hFCC0 | 16'h0010; nw_b = 16'hFCC0 | 16'h0020;
    step(0, 0, 1, 16'd20, "R3 cmpA field");
    nc_b = 16'd30; nw_a = 16'hFCC0 | 16'h0200; nw_b = 16'hFCC0 | 16'h0100;
    step(0, 0, 1, 16'd30, "R3 cmpB field");
    nw_a = 16'hFCC0; nw_b = 16'hFCC0;
    step(1, 1, 1, 16'd20, "R3 junk bits only");

    // R4 direction and mismatch
    nw_a = 16'h0330; nw_b = 16'h0330;
    step(0, 0, 0, 16'd20, "R4 match while down");
    step(0, 0, 0, 16'd30, "R4 matchB while down");
    step(0, 0, 1, 16'd21, "R4 mismatch up");
    step(0, 0, 1, 16'd20, "R4 match up");

    // R5 priority
    nc_a = 16'd7; nc_b = 16'd7;
    nw_a = 16'h0116 | 16'h0002; nw_b = 16'h0211 | 16'h0001;
    step(1, 1, 1, 16'd7, "R5 zero wins");
    nw_a = 16'h0118; nw_b = 16'h0124;
    step(0, 1, 1, 16'd7, "R5 period wins");
    nw_a = 16'h0120; nw_b = 16'h0210;
    step(0, 0, 1, 16'd7, "R5 cmpA beats cmpB");

    // R6 keep codes do not block
    nw_a = 16'h0200; nw_b = 16'h0010;
    step(1, 1, 1, 16'd7, "R6 fallthrough");
    nw_a = 16'h0014; nw_b = 16'h0028;
    step(1, 1, 1, 16'd7, "R6 to period");

    // R7 independence
    nw_a = 16'h0002; nw_b = 16'h0001;
    step(1, 0, 0, 16'd0, "R7 split");
    nw_a = 16'h0000; nw_b = 16'h0002;
    step(1, 0, 0, 16'd0, "R7 only B moves");
    settle();

    // R9 waveforms: A normal, B inverted
    nc_a = 16'd3; nc_b = 16'd40;
    nw_a = 16'h001A; nw_b = 16'h0025;
    nc_b = 16'd3;
    nw_b = 16'h0025;
    sweep(9, 0, "R9 warm");
    sweep(9, 1, "R9 run");
    settle();
    check(hi_a == 4, "R9 normal high cycles", hi_a, 4);
    check(lo_b == 4, "R9 inverted low cycles", lo_b, 4);

    hi_a = 0; lo_b = 0;
    nc_a = 16'd6; nc_b = 16'd6;
    sweep(12, 0, "R9 warm2");
    sweep(12, 1, "R9 run2");
    settle();
    check(hi_a == 7, "R9 normal high cycles 2", hi_a, 7);
    check(lo_b == 7, "R9 inverted low cycles 2", lo_b, 7);

    settle();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule